// File: doc/BRIEF.md
# Lease-Timed L1/L2 Coherence Controller

This block keeps a small L1 data cache coherent with its L2 home bank without any invalidation or acknowledgement traffic. When a load fills an L1 line, the home bank grants it a lease that ends a fixed number of ticks after the current global time. The L1 copy is usable only while that end time is still ahead of global time. After that the line dies by itself, and the next access refetches it from the home bank. The home bank keeps, for each word, the latest lease end it has granted. When that value is not ahead of global time, no live L1 copy can exist anywhere.

Stores write through to the home bank and never wait for outstanding leases to run out. The L1 copy is refreshed only when the line is present and still live. A store never allocates an L1 line. The core issues at most one request per cycle. Every request gets a registered response on the next cycle, carrying:

- the data,
- whether the L1 copy served or absorbed it,
- the L1 lease end,
- the home timestamp,
- a flag that says the word currently has no live copies.

Global time is an input. The block takes it as given, even if it does not increase.

Top module: `lease_coh_ctrl`

## Requirements
- R1: After reset `rsp_valid` is 0. Every L1 line is empty. Every home word holds data 0 and timestamp 0.
- R2: A load that finds no live L1 copy is a fill. It responds with `rsp_hit`=0, the home data, and `rsp_lease` = gtime+LEASE saturated at 2^TIME_W-1. It installs the line in L1 with that lease.
- R3: A load whose L1 line has a matching tag and lease end greater than gtime responds with `rsp_hit`=1, the L1 data, and `rsp_lease` equal to the L1 lease end. It leaves the home timestamp unchanged.
- R4: A line whose lease end is less than or equal to gtime is treated as absent. A load to it refetches from the home bank with a fresh lease.
- R5: On a fill the home timestamp becomes the larger of its old value and the new lease end, so it never decreases. `rsp_home_ts` reports the value after the request.
- R6: Every store writes its data into the home word in the cycle it is accepted. A later fill returns that data. A store responds with `rsp_rdata` = the stored data.
- R7: A store to a live L1 line updates the L1 data but not its lease. It responds with `rsp_hit`=1 and `rsp_lease` = the line's lease end.
- R8: A store to an absent or expired line responds with `rsp_hit`=0 and `rsp_lease`=0. It allocates no L1 line, and it leaves the home timestamp unchanged.
- R9: `rsp_quiet` is 1 exactly when the home timestamp after the request is less than or equal to the request's gtime.
- R10: Each request with `req_valid`=1 gives `rsp_valid`=1 on the next cycle. No request is ever stalled, and an idle cycle gives `rsp_valid`=0.
- R11: The L1 is direct-mapped: index = low L1_IDX_W address bits, tag = the remaining bits. A fill to another tag at the same index evicts the previous line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| gtime | input | TIME_W | Synchronized global time |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | L1 copy was live and served or absorbed the request |
| rsp_rdata | output | DATA_W | Load data, or the stored data for a store |
| rsp_lease | output | TIME_W | L1 lease end involved, 0 if none |
| rsp_home_ts | output | TIME_W | Home timestamp after the request |
| rsp_quiet | output | 1 | No live L1 copy of the word can exist |

## Verification
The bench aims at the lease boundary. It walks global time one tick at a time past a lease end. A design that compared with greater-or-equal would still hit at the expiry tick, and one that missed the saturation would wrap a late lease to a tiny value. It also targets the difference between a store to a live line and a store to an absent one. Allocating on a store, or skipping the L1 update, shows up on the next load as a wrong hit flag or stale data. Driving global time backwards checks that the home timestamp keeps its maximum instead of being overwritten. Index conflicts check that a neighbour's fill evicts the line.

// File: rtl/lease_coh_pkg.sv
package lease_coh_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_HIT   = 2'd1,
    OP_FILL  = 2'd2,
    OP_STORE = 2'd3
  } op_e;

  // end of a lease granted at time g, clamped to the largest time value
  function automatic int unsigned lease_end(int unsigned g, int unsigned len,
                                            int unsigned tmax);
    if (g > tmax - len) return tmax;
    return g + len;
  endfunction

  // a lease is usable only while its end lies strictly ahead of now
  function automatic logic ts_live(int unsigned ts, int unsigned now);
    return ts > now;
  endfunction

  function automatic int unsigned later_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lease_l1_store.sv
module lease_l1_store
  import lease_coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int TIME_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [TIME_W-1:0] gtime,
  output logic              lk_live,
  output logic [DATA_W-1:0] lk_data,
  output logic [TIME_W-1:0] lk_ts,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [TIME_W-1:0] fill_ts,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]   line_vld;
  logic [TAG_W-1:0]  line_tag  [SETS];
  logic [DATA_W-1:0] line_data [SETS];
  logic [TIME_W-1:0] line_ts   [SETS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             tag_match;

  assign idx       = lk_addr[IDX_W-1:0];
  assign tag       = lk_addr[ADDR_W-1:IDX_W];
  assign tag_match = line_vld[idx] && (line_tag[idx] == tag);
  assign lk_data   = line_data[idx];
  assign lk_ts     = line_ts[idx];
  assign lk_live   = tag_match && ts_live(32'(line_ts[idx]), 32'(gtime));

  always_ff @(posedge clk) begin
    if (!rst_n) line_vld <= '0;
    else if (fill_en) line_vld[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      line_tag[idx]  <= tag;
      line_data[idx] <= fill_data;
      line_ts[idx]   <= fill_ts;
    end else if (upd_en) begin
      line_data[idx] <= upd_data;
    end
  end
endmodule

// File: rtl/lease_l2_home.sv
module lease_l2_home
  import lease_coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [TIME_W-1:0] rd_ts,
  input  logic              grant_en,
  input  logic [TIME_W-1:0] grant_ts,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_data [DEPTH];
  logic [TIME_W-1:0] word_ts   [DEPTH];

  assign rd_data = word_data[addr];
  assign rd_ts   = word_ts[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        word_data[i] <= '0;
        word_ts[i]   <= '0;
      end
    end else begin
      if (wr_en)    word_data[addr] <= wr_data;
      if (grant_en) word_ts[addr]   <= TIME_W'(later_of(32'(word_ts[addr]), 32'(grant_ts)));
    end
  end
endmodule

// File: rtl/lease_coh_ctrl.sv
module lease_coh_ctrl
  import lease_coh_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 8,
  parameter int          TIME_W   = 8,
  parameter int          L1_IDX_W = 2,
  parameter int unsigned LEASE    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TIME_W-1:0] gtime,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [TIME_W-1:0] rsp_lease,
  output logic [TIME_W-1:0] rsp_home_ts,
  output logic              rsp_quiet
);
  localparam int unsigned TMAX = (32'd1 << TIME_W) - 32'd1;

  logic              l1_live;
  logic [DATA_W-1:0] l1_data;
  logic [TIME_W-1:0] l1_ts;
  logic [DATA_W-1:0] l2_data;
  logic [TIME_W-1:0] l2_ts;

  // named events for the checker
  op_e               op;
  logic              ev_fill;
  logic              ev_store_upd;
  logic              ev_store_skip;
  logic [TIME_W-1:0] new_lease;
  logic [TIME_W-1:0] home_after;

  always_comb begin
    if (!req_valid)     op = OP_IDLE;
    else if (req_write) op = OP_STORE;
    else if (l1_live)   op = OP_HIT;
    else                op = OP_FILL;
  end

  assign ev_fill       = (op == OP_FILL);
  assign ev_store_upd  = (op == OP_STORE) && l1_live;
  assign ev_store_skip = (op == OP_STORE) && !l1_live;
  assign new_lease     = TIME_W'(lease_end(32'(gtime), LEASE, TMAX));
  assign home_after    = ev_fill ? TIME_W'(later_of(32'(l2_ts), 32'(new_lease))) : l2_ts;

  lease_l1_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W), .IDX_W(L1_IDX_W)
  ) u_l1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (req_addr),
    .gtime    (gtime),
    .lk_live  (l1_live),
    .lk_data  (l1_data),
    .lk_ts    (l1_ts),
    .fill_en  (ev_fill),
    .fill_data(l2_data),
    .fill_ts  (new_lease),
    .upd_en   (ev_store_upd),
    .upd_data (req_wdata)
  );

  lease_l2_home #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W)
  ) u_l2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (req_addr),
    .rd_data (l2_data),
    .rd_ts   (l2_ts),
    .grant_en(ev_fill),
    .grant_ts(new_lease),
    .wr_en   (op == OP_STORE),
    .wr_data (req_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_rdata   <= '0;
      rsp_lease   <= '0;
      rsp_home_ts <= '0;
      rsp_quiet   <= 1'b0;
    end else begin
      rsp_valid   <= (op != OP_IDLE);
      rsp_home_ts <= home_after;
      rsp_quiet   <= !ts_live(32'(home_after), 32'(gtime));
      unique case (op)
        OP_HIT: begin
          rsp_hit   <= 1'b1;
          rsp_rdata <= l1_data;
          rsp_lease <= l1_ts;
        end
        OP_FILL: begin
          rsp_hit   <= 1'b0;
          rsp_rdata <= l2_data;
          rsp_lease <= new_lease;
        end
        OP_STORE: begin
          rsp_hit   <= ev_store_upd;
          rsp_rdata <= req_wdata;
          rsp_lease <= ev_store_upd ? l1_ts : '0;
        end
        default: begin
          rsp_hit   <= 1'b0;
          rsp_rdata <= '0;
          rsp_lease <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lease_coh_checker.sv
module lease_coh_checker #(
  parameter int          TIME_W = 8,
  parameter int unsigned LEASE  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TIME_W-1:0] gtime,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [TIME_W-1:0] rsp_lease,
  input logic [TIME_W-1:0] rsp_home_ts,
  input logic              ev_fill,
  input logic              ev_store_skip
);
  localparam int unsigned TMAX = (32'd1 << TIME_W) - 32'd1;

  logic [TIME_W:0] grant_sum;
  assign grant_sum = {1'b0, gtime} + (TIME_W+1)'(LEASE);

  logic [TIME_W-1:0] grant_exp;
  assign grant_exp = (grant_sum > (TIME_W+1)'(TMAX)) ? TIME_W'(TMAX) : grant_sum[TIME_W-1:0];

  // R10
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3 / R7: a reported hit always rode on a lease still ahead of its request's time
  a_r3_hit_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid ##1 (rsp_valid && rsp_hit) |-> rsp_lease > $past(gtime));
  // R2
  a_r2_fill_lease: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> rsp_lease == $past(grant_exp));
  // R5: the home timestamp covers every lease it reports
  a_r5_home_covers: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_home_ts >= rsp_lease);
  // R8
  a_r8_store_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store_skip |=> (!rsp_hit && rsp_lease == '0));
endmodule

bind lease_coh_ctrl lease_coh_checker #(.TIME_W(TIME_W), .LEASE(LEASE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .gtime        (gtime),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_lease    (rsp_lease),
  .rsp_home_ts  (rsp_home_ts),
  .ev_fill      (ev_fill),
  .ev_store_skip(ev_store_skip)
);

// File: tb/lease_coh_ctrl_bench.sv
module lease_coh_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 8, TW = 8, IW = 2, LS = 10;
  localparam int NWORD = 1 << AW, NSET = 1 << IW, TOP = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW-1:0] gtime = '0;
  logic          rsp_valid, rsp_hit, rsp_quiet;
  logic [DW-1:0] rsp_rdata;
  logic [TW-1:0] rsp_lease, rsp_home_ts;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lease_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TIME_W(TW), .L1_IDX_W(IW), .LEASE(LS)) u_lease_coh_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .gtime(gtime),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .rsp_lease(rsp_lease), .rsp_home_ts(rsp_home_ts), .rsp_quiet(rsp_quiet)
  );

  // reference state, kept from the requirements
  bit m_vld [NSET];
  int m_tag [NSET], m_dat [NSET], m_ts [NSET];
  int h_dat [NWORD], h_ts [NWORD];

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, int a, int d, int t);
    int ix = a % NSET, tg = a / NSET;
    bit live = m_vld[ix] && m_tag[ix] == tg && m_ts[ix] > t;
    int e_hit, e_dat, e_ls, e_home;
    string tag;
    if (wr) begin
      tag = live ? "R7" : "R8";
      h_dat[a] = d;
      if (live) m_dat[ix] = d;
      e_hit = live; e_dat = d; e_ls = live ? m_ts[ix] : 0; e_home = h_ts[a];
    end else if (live) begin
      tag = "R3";
      e_hit = 1; e_dat = m_dat[ix]; e_ls = m_ts[ix]; e_home = h_ts[a];
    end else begin
      tag = (m_vld[ix] && m_tag[ix] == tg) ? "R4" : "R2";
      e_ls = (t + LS > TOP) ? TOP : t + LS;
      e_hit = 0; e_dat = h_dat[a];
      if (e_ls > h_ts[a]) h_ts[a] = e_ls;
      e_home = h_ts[a];
      m_vld[ix] = 1; m_tag[ix] = tg; m_dat[ix] = h_dat[a]; m_ts[ix] = e_ls;
    end
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = DW'(d); gtime = TW'(t);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "rsp_valid", int'(rsp_valid), 1);
    check(tag, "rsp_hit", int'(rsp_hit), e_hit);
    check(wr ? "R6" : tag, "rsp_rdata", int'(rsp_rdata), e_dat);
    check(tag, "rsp_lease", int'(rsp_lease), e_ls);
    check("R5", "rsp_home_ts", int'(rsp_home_ts), e_home);
    check("R9", "rsp_quiet", int'(rsp_quiet), int'(e_home <= t));
  endtask

  initial begin
    for (int i = 0; i < NSET; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_dat[i] = 0; m_ts[i] = 0; end
    for (int i = 0; i < NWORD; i++) begin h_dat[i] = 0; h_ts[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R2/R11: cold loads over every word, later ones evict earlier ones per set
    for (int a = 0; a < NWORD; a++) access(0, a, 0, 0);
    // R6/R7/R8: stores over every word; only the last occupant of each set is live
    for (int a = 0; a < NWORD; a++) access(1, a, (a * 3 + 1) % 256, 1);
    // R6/R3: reload every word
    for (int a = 0; a < NWORD; a++) access(0, a, 0, 2);
    // R4: walk time across a lease end tick by tick
    access(0, 5, 0, 100);
    for (int d = 1; d <= 12; d++) access(0, 5, 0, 100 + d);
    // R9: stored-to word with an expired lease reports quiet, no waiting
    access(0, 7, 0, 120);
    access(1, 7, 77, 125);
    access(1, 7, 78, 131);
    access(0, 7, 0, 131);
    // R5 / R11: conflict evicts, then time runs backwards; home keeps the max
    access(0, 9, 0, 200);
    access(0, 13, 0, 200);
    access(0, 9, 0, 150);
    access(0, 9, 0, 151);
    // R2: lease saturation at the top of the time range
    access(0, 20, 0, 250);
    access(0, 20, 0, 254);
    access(0, 20, 0, 255);
    // R8: store to absent word does not allocate
    access(1, 33, 99, 255);
    access(0, 33, 0, 40);
    // R10: idle cycle
    @(negedge clk);
    check("R10", "idle rsp_valid", int'(rsp_valid), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule